// File: doc/BRIEF.md
# Serial Divider Programming Port

This block loads the divider settings of a frequency synthesizer from a three-wire serial link: a shift clock, a data line and a load enable. A 32-stage shift register takes one data bit on each rising edge of the shift clock. Behind it sit two holding registers that drive the parallel divider outputs. One holds the 14-bit reference divide value. The other holds the 10-bit main (N) value and the 7-bit swallow (A) value together.

The last bit shifted in is a steering bit. While the load enable is high, the N/A register always follows the shift register. The reference register follows it only when the steering bit is 1. While the load enable is low, all three divider outputs hold their values. The oldest bit in the shift register is driven out, not inverted, on a serial output so that devices can be chained. The load enable has no effect on that output.

The serial pins are sampled by the block's own clock. They pass through an optional synchroniser chain whose depth is a parameter, and a rising-edge detector turns the sampled shift clock into a one-cycle shift strobe. The block's outputs are the latched R, N and A values, for the divider blocks to use.

Top module: `prog_serial_port`

## Requirements
- R1: Each rising edge of `ser_clk` (a low sample followed by a high sample) shifts the register by one place and takes `ser_data` into the newest stage. The bit shifted in appears on `ser_out` after 32 such edges.
- R2: `ser_out` is the oldest stage of the 32-bit shift register, not inverted, and its value does not depend on `load_en`.
- R3: While `load_en` is high and the newest stage (the steering bit) is 1, `ref_div` takes the reference field of the shift register on the next clock.
- R4: While `load_en` is high and the steering bit is 0, `ref_div` keeps its value.
- R5: While `load_en` is high, `n_div` and `a_div` take their fields on the next clock, whatever the steering bit holds.
- R6: While `load_en` is low, `ref_div`, `n_div` and `a_div` do not change, even while bits are being shifted.
- R7: The holding registers are transparent: if the register shifts while `load_en` stays high, the outputs follow the new contents one clock later.
- R8: While `rst_n` is low, the shift register and all three holding registers are zero, so `ser_out`, `ref_div`, `n_div` and `a_div` all read 0.
- R9: The frame is 32 bits, sent in this order: the reference field (14 bits, MSB first), then N (10 bits, MSB first), then A (7 bits, MSB first), then the steering bit. After a full frame, register bits 31..18 hold R, bits 17..8 hold N, bits 7..1 hold A, and bit 0 holds the steering bit.
- R10: Holding `ser_clk` at either level causes no further shift, whatever `ser_data` does in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock; a rising edge shifts one bit |
| ser_data | input | 1 | Serial data, taken at each shift |
| load_en | input | 1 | Load enable; idles low and is pulsed high to transfer |
| ser_out | output | 1 | Oldest shift-register stage, for chaining |
| ref_div | output | 14 | Latched reference divide value |
| n_div | output | 10 | Latched main divide value |
| a_div | output | 7 | Latched swallow count |

## Verification
The assertions assume that the serial pins change slowly compared with `clk`. Each level of `ser_clk` has to be seen for at least one sample, so that every rising edge gives exactly one shift strobe. `ser_data` has to be stable at the sample where the edge is detected. The stimulus changes each pin only at the falling edge of `clk`. It holds each `ser_clk` level for two cycles and sets `ser_data` in the same cycle that the clock rises. Each `load_en` pulse lasts two cycles and is given only while no shift is in progress, except in the test that checks transparency on purpose.

// File: rtl/prog_serial_pkg.sv
package prog_serial_pkg;
   localparam int REF_W_DFLT  = 14;
   localparam int N_W_DFLT    = 10;
   localparam int A_W_DFLT    = 7;
   localparam int STEER_W     = 1;

   function automatic int frame_len(input int r_w, input int n_w, input int a_w);
      return r_w + n_w + a_w + STEER_W;
   endfunction
endpackage

// File: rtl/prog_in_sync.sv
module prog_in_sync #(
   parameter int STAGES = 0,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("prog_in_sync: W must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("prog_in_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/prog_rise_det.sv
module prog_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/prog_shreg.sv
module prog_shreg #(
   parameter int LEN = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shift,
   input  logic           din,
   output logic [LEN-1:0] q
);
   if (LEN < 1) begin : g_bad_len
      $error("prog_shreg: LEN must be at least 1");
   end

   if (LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= '0;
         else if (shift) q <= din;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= '0;
         else if (shift) q <= {q[LEN-2:0], din};
      end
   end
endmodule

// File: rtl/prog_hold_reg.sv
module prog_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("prog_hold_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/prog_serial_port.sv
module prog_serial_port
   import prog_serial_pkg::*;
#(
   parameter int R_W         = REF_W_DFLT,
   parameter int N_W         = N_W_DFLT,
   parameter int A_W         = A_W_DFLT,
   parameter int SYNC_STAGES = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           load_en,
   output logic           ser_out,
   output logic [R_W-1:0] ref_div,
   output logic [N_W-1:0] n_div,
   output logic [A_W-1:0] a_div
);
   localparam int STEER_POS = 0;
   localparam int A_LSB     = STEER_POS + STEER_W;
   localparam int N_LSB     = A_LSB + A_W;
   localparam int R_LSB     = N_LSB + N_W;
   localparam int SR_LEN    = frame_len(R_W, N_W, A_W);

   if (R_W < 1 || N_W < 1 || A_W < 1) begin : g_bad_fields
      $error("prog_serial_port: every field width must be at least 1");
   end
   if (R_LSB + R_W != SR_LEN) begin : g_bad_layout
      $error("prog_serial_port: field layout does not fill the frame");
   end

   logic [2:0]        pins_s;
   logic              sclk_s;
   logic              data_s;
   logic              load_s;
   logic              sclk_rise;
   logic [SR_LEN-1:0] shreg;
   logic              na_load;
   logic              ref_load;

   prog_in_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_clk, ser_data, load_en}),
      .q    (pins_s)
   );

   assign sclk_s = pins_s[2];
   assign data_s = pins_s[1];
   assign load_s = pins_s[0];

   prog_rise_det u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (sclk_s),
      .rise (sclk_rise)
   );

   prog_shreg #(.LEN(SR_LEN)) u_shreg (
      .clk  (clk),
      .rst_n(rst_n),
      .shift(sclk_rise),
      .din  (data_s),
      .q    (shreg)
   );

   assign ser_out  = shreg[SR_LEN-1];
   assign na_load  = load_s;
   assign ref_load = load_s & shreg[STEER_POS];

   prog_hold_reg #(.W(R_W)) u_ref_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ref_load),
      .d    (shreg[R_LSB +: R_W]),
      .q    (ref_div)
   );

   prog_hold_reg #(.W(N_W + A_W)) u_na_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (na_load),
      .d    (shreg[A_LSB +: N_W + A_W]),
      .q    ({n_div, a_div})
   );
endmodule

// File: rtl/prog_serial_port_chk.sv
module prog_serial_port_chk #(
   parameter int R_W = 14,
   parameter int N_W = 10,
   parameter int A_W = 7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       ser_out,
   input logic [R_W-1:0]             ref_div,
   input logic [N_W-1:0]             n_div,
   input logic [A_W-1:0]             a_div,
   input logic                       data_s,
   input logic                       load_s,
   input logic                       sclk_rise,
   input logic [R_W+N_W+A_W:0]       shreg
);
   localparam int LEN = R_W + N_W + A_W + 1;

   // R1: a strobe moves the register one place and takes the data bit
   a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> (shreg[LEN-1:1] == $past(shreg[LEN-2:0]) && shreg[0] == $past(data_s)));

   // R10: no strobe, no movement
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(shreg));

   // R2: serial output takes the second-oldest stage after a shift
   a_r2_ser_out: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> ser_out == $past(shreg[LEN-2]));

   // R3: steering bit set lets the reference register load
   a_r3_ref_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load_s && shreg[0]) |=> ref_div == $past(shreg[LEN-1 -: R_W]));

   // R4: steering bit clear blocks the reference register
   a_r4_ref_block: assert property (@(posedge clk) disable iff (!rst_n)
      (load_s && !shreg[0]) |=> $stable(ref_div));

   // R5: N/A register loads whenever enabled
   a_r5_na_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_s |=> {n_div, a_div} == $past(shreg[LEN-1-R_W:1]));

   // R6: enable low holds all outputs
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_s |=> $stable({ref_div, n_div, a_div}));

   // R8: reset clears every visible value
   a_r8_reset: assert property (@(posedge clk)
      !rst_n |-> (ref_div == '0 && n_div == '0 && a_div == '0 && !ser_out));
endmodule

bind prog_serial_port prog_serial_port_chk #(.R_W(R_W), .N_W(N_W), .A_W(A_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ser_out  (ser_out),
   .ref_div  (ref_div),
   .n_div    (n_div),
   .a_div    (a_div),
   .data_s   (data_s),
   .load_s   (load_s),
   .sclk_rise(sclk_rise),
   .shreg    (shreg)
);

// File: tb/sim_prog_serial_port.sv
`timescale 1ns/1ps
module sim_prog_serial_port;
   localparam int NV = 6;
   localparam logic [31:0] VEC [NV] = '{
      {14'h1234, 10'h155, 7'h2A, 1'b1},
      {14'h3FFF, 10'h3FF, 7'h7F, 1'b0},
      {14'h0003, 10'h010, 7'h00, 1'b1},
      {14'h2AAA, 10'h2AA, 7'h55, 1'b0},
      {14'h3FFF, 10'h3FF, 7'h7F, 1'b1},
      {14'h0000, 10'h000, 7'h00, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_data = 1'b0;
   logic        load_en = 1'b0;
   logic        ser_out;
   logic [13:0] ref_div;
   logic [9:0]  n_div;
   logic [6:0]  a_div;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [13:0] exp_r;
   logic [31:0] w;

   always #4 clk = ~clk;

   prog_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .load_en(load_en), .ser_out(ser_out), .ref_div(ref_div),
      .n_div(n_div), .a_div(a_div)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b);
      @(negedge clk); ser_data = b; ser_clk = 1'b1;
      @(negedge clk);
      @(negedge clk); ser_clk = 1'b0;
      @(negedge clk);
   endtask

   task automatic shift_word(input logic [31:0] v);
      for (int i = 31; i >= 0; i--) shift_bit(v[i]);
   endtask

   task automatic pulse_load(input logic exp_so);
      @(negedge clk); load_en = 1'b1;
      @(negedge clk);
      check("R2 ser_out with enable high", {31'b0, ser_out}, {31'b0, exp_so});
      @(negedge clk); load_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_outs(input string tag, input logic [31:0] v);
      check({tag, " ref_div"}, {18'b0, ref_div}, {18'b0, exp_r});
      check({tag, " n_div"},   {22'b0, n_div},   {22'b0, v[17:8]});
      check({tag, " a_div"},   {25'b0, a_div},   {25'b0, v[7:1]});
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      exp_r = '0;
      // R8: reset state
      repeat (3) @(negedge clk);
      check("R8 reset ref", {18'b0, ref_div}, 32'h0);
      check("R8 reset n/a", {15'b0, n_div, a_div}, 32'h0);
      check("R8 reset ser_out", {31'b0, ser_out}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9 / R3 / R4 / R5 / R1: table walk
      foreach (VEC[k]) begin
         shift_word(VEC[k]);
         check("R1 first bit reaches ser_out", {31'b0, ser_out}, {31'b0, VEC[k][31]});
         pulse_load(VEC[k][31]);
         if (VEC[k][0]) exp_r = VEC[k][31:18];
         check_outs(VEC[k][0] ? "R3 R9 R5" : "R4 R9 R5", VEC[k]);
      end

      // R6: shifting with enable low leaves outputs untouched
      w = VEC[5];
      shift_word({14'h1555, 10'h2B3, 7'h19, 1'b1});
      check_outs("R6 hold", w);
      check("R2 ser_out enable low", {31'b0, ser_out}, 32'h0);

      // R10: clock held high while data toggles gives a single shift
      @(negedge clk); ser_data = 1'b1; ser_clk = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); ser_data = ~ser_data;
      end
      ser_clk = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); ser_data = ~ser_data;
      end
      w = {14'h1555, 10'h2B3, 7'h19, 1'b1};
      w = {w[30:0], 1'b1};
      check("R10 single shift ser_out", {31'b0, ser_out}, {31'b0, w[31]});
      pulse_load(w[31]);
      exp_r = w[31:18];
      check_outs("R10 R3", w);

      // R7: transparency while enable stays high
      @(negedge clk); load_en = 1'b1;
      shift_bit(1'b0);
      w = {w[30:0], 1'b0};
      check_outs("R7 R5 transparent", w);
      shift_bit(1'b1);
      w = {w[30:0], 1'b1};
      exp_r = w[31:18];
      check_outs("R7 R3 transparent", w);
      @(negedge clk); load_en = 1'b0;

      // R8: reset in mid-operation
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R8 mid reset ref", {18'b0, ref_div}, 32'h0);
      check("R8 mid reset n/a", {15'b0, n_div, a_div}, 32'h0);
      check("R8 mid reset ser_out", {31'b0, ser_out}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      finish_run();
   end
endmodule